// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences the power-down and wake-up of a small microcontroller core. A sleep strobe from the instruction pipeline stops the core clock, clears the watchdog and records entry into power-down in two status bits. The block then waits for one of three wake events: an external reset request, a watchdog time-out (only when the watchdog is enabled), or an interrupt source whose own enable bit is set together with its flag.

A reset request restarts the core at once. A watchdog or interrupt wake resumes execution without a reset. In crystal oscillator modes the block first lets the oscillator settle for a programmable number of cycles; in RC mode it resumes immediately. After resuming, the core runs the instruction that followed the sleep instruction. If an interrupt woke the core and the global interrupt enable was set, the block then asks the core to branch to the interrupt vector. The two status bits let firmware tell apart power-up, a reset out of sleep, a watchdog reset and a watchdog wake.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, pd_o=1, to_o=1, clk_en_o=1, and wdt_clr_o, core_rst_o, resume_o and vector_o are 0.
- R2: A sleep_i strobe while running, with no reset request and no enabled watchdog time-out in the same cycle, gives pd_o=0, to_o=1 and clk_en_o=0 on the next cycle, together with a one-cycle wdt_clr_o pulse.
- R3: While asleep, the block wakes on an enabled watchdog time-out (wdt_en_i=1 and wdt_tmo_i=1) or on any bit i with irq_flag_i[i]=1 and irq_en_i[i]=1. A flag whose enable is 0, or a time-out while wdt_en_i=0, leaves the block asleep with clk_en_o=0. gie_i has no effect on whether the block wakes.
- R4: ext_rst_i=1 in any state gives core_rst_o=1 and clk_en_o=1 on the next cycle, returns the block to running, and leaves pd_o and to_o unchanged, with no resume_o pulse.
- R5: A wake that includes a watchdog time-out clears to_o. An interrupt-only wake leaves to_o=1. Neither kind of wake asserts core_rst_o.
- R6: Every watchdog or interrupt wake pulses wdt_clr_o for one cycle, in the cycle after the wake event is sampled.
- R7: With osc_rc_i=0, resume_o pulses and clk_en_o returns to 1 exactly OST_CYCLES cycles after the wdt_clr_o wake pulse. With osc_rc_i=1, both happen in the same cycle as the wdt_clr_o wake pulse.
- R8: vector_o pulses for one cycle, INSN_CYCLES cycles after resume_o, only when an interrupt source was pending at the wake and gie_i=1 at the wake. A wake with gie_i=0 or with no pending interrupt never produces vector_o.
- R9: If an enabled interrupt is pending when sleep_i arrives, the sleep still completes (pd_o=0, clk_en_o=0 for one cycle), and the block wakes on the following cycle.
- R10: While running, wdt_en_i=1 with wdt_tmo_i=1 gives a one-cycle core_rst_o pulse and to_o=0 on the next cycle, with pd_o unchanged. With wdt_en_i=0 the time-out has no effect.
- R11: During oscillator start-up and the resume instruction window, sleep_i and watchdog time-outs are ignored: to_o and pd_o hold, core_rst_o stays 0, and resume_o keeps its R7 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| sleep_i | input | 1 | One-cycle strobe from the executed sleep instruction |
| ext_rst_i | input | 1 | External reset request |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_tmo_i | input | 1 | Watchdog time-out pulse |
| irq_flag_i | input | N_IRQ | Interrupt source flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| osc_rc_i | input | 1 | 1 = RC oscillator mode, so no start-up wait |
| clk_en_o | output | 1 | Core clock gate enable |
| wdt_clr_o | output | 1 | One-cycle watchdog clear |
| core_rst_o | output | 1 | Core reset pulse |
| resume_o | output | 1 | One-cycle strobe: resume at the instruction after the sleep instruction |
| vector_o | output | 1 | One-cycle request to branch to the interrupt vector |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |

## Verification
The bench builds the block with N_IRQ=3, OST_CYCLES=16 and INSN_CYCLES=4. The short start-up window lets each crystal-mode wake be traced cycle by cycle up to the exact resume edge. It also leaves room to inject a sleep strobe and a watchdog time-out in the middle of start-up. Three interrupt lines are enough to show a flag without its enable being ignored next to an enabled source on a different bit.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_SLEEP     = 2'd1,
    ST_OSC_START = 2'd2,
    ST_RESUME    = 2'd3
  } swc_state_e;
endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             wdt_en_i,
  input  logic             wdt_tmo_i,
  output logic             irq_wake_o,
  output logic             wdt_wake_o
);
  logic [N_IRQ-1:0] pend;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign pend[i] = irq_flag_i[i] & irq_en_i[i];
  end

  assign irq_wake_o = |pend;
  assign wdt_wake_o = wdt_en_i & wdt_tmo_i;
endmodule

// File: rtl/swc_delay_counter.sv
module swc_delay_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == last_i);
endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_set_i,
  input  logic to_clr_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else if (sleep_set_i) begin
      pd_o <= 1'b0;
      to_o <= 1'b1;
    end else if (to_clr_i) begin
      to_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int OST_CYCLES  = 1024,
  parameter int INSN_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             ext_rst_i,
  input  logic             wdt_en_i,
  input  logic             wdt_tmo_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             gie_i,
  input  logic             osc_rc_i,
  output logic             clk_en_o,
  output logic             wdt_clr_o,
  output logic             core_rst_o,
  output logic             resume_o,
  output logic             vector_o,
  output logic             pd_o,
  output logic             to_o
);
  localparam int MAX_CYC = (OST_CYCLES > INSN_CYCLES) ? OST_CYCLES : INSN_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] OST_LAST  = CNT_W'(OST_CYCLES - 1);
  localparam logic [CNT_W-1:0] INSN_LAST = CNT_W'(INSN_CYCLES - 1);

  swc_state_e state_q;
  logic irq_wake, wdt_wake;
  logic go_sleep, run_wdt_rst, wake;
  logic cnt_clear, cnt_done;
  logic [CNT_W-1:0] cnt_last;
  logic vec_pend_q;

  swc_wake_detect #(.N_IRQ(N_IRQ)) u_detect (
    .irq_flag_i (irq_flag_i),
    .irq_en_i   (irq_en_i),
    .wdt_en_i   (wdt_en_i),
    .wdt_tmo_i  (wdt_tmo_i),
    .irq_wake_o (irq_wake),
    .wdt_wake_o (wdt_wake)
  );

  assign go_sleep    = (state_q == ST_RUN) & sleep_i & ~ext_rst_i & ~wdt_wake;
  assign run_wdt_rst = (state_q == ST_RUN) & wdt_wake & ~ext_rst_i;
  assign wake        = (state_q == ST_SLEEP) & ~ext_rst_i & (irq_wake | wdt_wake);

  swc_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_set_i (go_sleep),
    .to_clr_i    (run_wdt_rst | (wake & wdt_wake)),
    .pd_o        (pd_o),
    .to_o        (to_o)
  );

  // counter restarts outside the timed states and at the start-up/resume boundary
  assign cnt_clear = ext_rst_i
                   | ((state_q != ST_OSC_START) & (state_q != ST_RESUME))
                   | ((state_q == ST_OSC_START) & cnt_done);
  assign cnt_last  = (state_q == ST_OSC_START) ? OST_LAST : INSN_LAST;

  swc_delay_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (cnt_clear),
    .last_i  (cnt_last),
    .done_o  (cnt_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      clk_en_o   <= 1'b1;
      wdt_clr_o  <= 1'b0;
      core_rst_o <= 1'b0;
      resume_o   <= 1'b0;
      vector_o   <= 1'b0;
      vec_pend_q <= 1'b0;
    end else begin
      wdt_clr_o  <= 1'b0;
      core_rst_o <= 1'b0;
      resume_o   <= 1'b0;
      vector_o   <= 1'b0;
      if (ext_rst_i) begin
        state_q    <= ST_RUN;
        clk_en_o   <= 1'b1;
        core_rst_o <= 1'b1;
        vec_pend_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (run_wdt_rst) begin
              core_rst_o <= 1'b1;
            end else if (go_sleep) begin
              state_q   <= ST_SLEEP;
              clk_en_o  <= 1'b0;
              wdt_clr_o <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (wake) begin
              wdt_clr_o  <= 1'b1;
              vec_pend_q <= irq_wake & gie_i;
              if (osc_rc_i) begin
                state_q  <= ST_RESUME;
                resume_o <= 1'b1;
                clk_en_o <= 1'b1;
              end else begin
                state_q <= ST_OSC_START;
              end
            end
          end
          ST_OSC_START: begin
            if (cnt_done) begin
              state_q  <= ST_RESUME;
              resume_o <= 1'b1;
              clk_en_o <= 1'b1;
            end
          end
          ST_RESUME: begin
            if (cnt_done) begin
              state_q    <= ST_RUN;
              vector_o   <= vec_pend_q;
              vec_pend_q <= 1'b0;
            end
          end
          default: state_q <= ST_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/swc_checker.sv
module swc_checker
  import swc_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic             ext_rst_i,
  input logic             wdt_en_i,
  input logic             wdt_tmo_i,
  input logic [N_IRQ-1:0] irq_flag_i,
  input logic [N_IRQ-1:0] irq_en_i,
  input logic             clk_en_o,
  input logic             wdt_clr_o,
  input logic             core_rst_o,
  input logic             resume_o,
  input logic             vector_o,
  input logic             pd_o,
  input logic             to_o,
  input swc_state_e       state_i
);
  logic irq_pend, wdt_hit;
  assign irq_pend = |(irq_flag_i & irq_en_i);
  assign wdt_hit  = wdt_en_i & wdt_tmo_i;

  a_r2_sleep_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && sleep_i && !ext_rst_i && !wdt_hit)
      |=> (!pd_o && to_o && !clk_en_o && wdt_clr_o));

  a_r3_stay_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP && !ext_rst_i && !wdt_hit && !irq_pend)
      |=> (!clk_en_o && !wdt_clr_o && !resume_o));

  a_r4_ext_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rst_i |=> (core_rst_o && clk_en_o && !resume_o && $stable(pd_o)));

  a_r5_irq_wake_keeps_to: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP && !ext_rst_i && !wdt_hit && irq_pend)
      |=> (to_o && !core_rst_o && wdt_clr_o));

  a_r7_resume_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  a_r8_vector_clocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o |-> (clk_en_o && !resume_o));

  a_r10_run_wdt_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && wdt_hit && !ext_rst_i) |=> (core_rst_o && !to_o && $stable(pd_o)));

  a_r11_timed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_OSC_START || state_i == ST_RESUME) && !ext_rst_i)
      |=> ($stable(to_o) && $stable(pd_o) && !core_rst_o));
endmodule

bind sleep_wake_ctrl swc_checker #(.N_IRQ(N_IRQ)) u_swc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_i    (sleep_i),
  .ext_rst_i  (ext_rst_i),
  .wdt_en_i   (wdt_en_i),
  .wdt_tmo_i  (wdt_tmo_i),
  .irq_flag_i (irq_flag_i),
  .irq_en_i   (irq_en_i),
  .clk_en_o   (clk_en_o),
  .wdt_clr_o  (wdt_clr_o),
  .core_rst_o (core_rst_o),
  .resume_o   (resume_o),
  .vector_o   (vector_o),
  .pd_o       (pd_o),
  .to_o       (to_o),
  .state_i    (state_q)
);

// File: tb/sleep_wake_ctrl_bench.sv
`timescale 1ns/100ps
module sleep_wake_ctrl_bench;
  localparam int N_IRQ = 3;
  localparam int OST   = 16;
  localparam int INSN  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 0, ext_rst_i = 0, wdt_en_i = 0, wdt_tmo_i = 0, gie_i = 0, osc_rc_i = 0;
  logic [N_IRQ-1:0] irq_flag_i = '0, irq_en_i = '0;
  logic clk_en_o, wdt_clr_o, core_rst_o, resume_o, vector_o, pd_o, to_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sleep_wake_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST), .INSN_CYCLES(INSN)) u_sleep_wake_ctrl (
    .clk_i, .rst_ni, .sleep_i, .ext_rst_i, .wdt_en_i, .wdt_tmo_i,
    .irq_flag_i, .irq_en_i, .gie_i, .osc_rc_i,
    .clk_en_o, .wdt_clr_o, .core_rst_o, .resume_o, .vector_o, .pd_o, .to_o
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
    chk("R1", "pd", pd_o, 1); chk("R1", "to", to_o, 1);
    chk("R1", "clk_en", clk_en_o, 1); chk("R1", "wdt_clr", wdt_clr_o, 0);
    chk("R1", "core_rst", core_rst_o, 0); chk("R1", "resume", resume_o, 0);
    chk("R1", "vector", vector_o, 0);
  endtask

  task automatic t_irq_xtal_gie0();
    osc_rc_i = 0; gie_i = 0;
    sleep_i = 1; step(); sleep_i = 0;
    chk("R2", "pd", pd_o, 0); chk("R2", "to", to_o, 1);
    chk("R2", "clk_en", clk_en_o, 0); chk("R2", "wdt_clr", wdt_clr_o, 1);
    step();
    chk("R2", "wdt_clr single", wdt_clr_o, 0);
    irq_flag_i = 3'b010; step();
    chk("R3", "flag w/o enable clk_en", clk_en_o, 0);
    chk("R3", "flag w/o enable wdt_clr", wdt_clr_o, 0);
    irq_flag_i = '0; wdt_tmo_i = 1; step(); wdt_tmo_i = 0;
    chk("R3", "tmo w/o wdt_en clk_en", clk_en_o, 0);
    chk("R3", "tmo w/o wdt_en to", to_o, 1);
    irq_flag_i = 3'b100; irq_en_i = 3'b100; step();
    irq_flag_i = '0; irq_en_i = '0;
    chk("R6", "wake wdt_clr", wdt_clr_o, 1);
    chk("R7", "no early resume", resume_o, 0);
    chk("R5", "irq wake to", to_o, 1);
    for (int i = 1; i < OST; i++) begin
      step();
      chk("R7", "resume held off", resume_o, 0);
    end
    step();
    chk("R7", "resume at start-up end", resume_o, 1);
    chk("R7", "clk_en at start-up end", clk_en_o, 1);
    for (int i = 0; i < INSN; i++) begin
      step();
      chk("R8", "no vector gie=0", vector_o, 0);
    end
  endtask

  task automatic t_irq_rc_gie1();
    osc_rc_i = 1; gie_i = 1;
    sleep_i = 1; step(); sleep_i = 0;
    step();
    irq_flag_i = 3'b001; irq_en_i = 3'b001; step();
    irq_flag_i = '0; irq_en_i = '0; gie_i = 0;
    chk("R7", "rc resume immediate", resume_o, 1);
    chk("R6", "rc wake wdt_clr", wdt_clr_o, 1);
    chk("R5", "irq wake no reset", core_rst_o, 0);
    for (int i = 1; i < INSN; i++) begin
      step();
      chk("R8", "vector not yet", vector_o, 0);
    end
    step();
    chk("R8", "vector after one insn", vector_o, 1);
    step();
    chk("R8", "vector single", vector_o, 0);
  endtask

  task automatic t_wdt_wake();
    osc_rc_i = 1; gie_i = 1; wdt_en_i = 1;
    sleep_i = 1; step(); sleep_i = 0;
    wdt_tmo_i = 1; step(); wdt_tmo_i = 0;
    chk("R5", "wdt wake to", to_o, 0);
    chk("R5", "wdt wake no reset", core_rst_o, 0);
    chk("R3", "wdt wake resume", resume_o, 1);
    chk("R6", "wdt wake wdt_clr", wdt_clr_o, 1);
    for (int i = 0; i < INSN + 1; i++) begin
      step();
      chk("R8", "wdt wake no vector", vector_o, 0);
    end
    wdt_en_i = 0; gie_i = 0;
  endtask

  task automatic t_pending_at_sleep();
    osc_rc_i = 1;
    irq_flag_i = 3'b010; irq_en_i = 3'b010;
    sleep_i = 1; step(); sleep_i = 0;
    chk("R9", "pd", pd_o, 0); chk("R9", "clk_en", clk_en_o, 0);
    step();
    irq_flag_i = '0; irq_en_i = '0;
    chk("R9", "immediate wake", resume_o, 1);
    chk("R9", "wake wdt_clr", wdt_clr_o, 1);
    repeat (INSN) step();
  endtask

  task automatic t_ext_rst_in_sleep();
    sleep_i = 1; step(); sleep_i = 0;
    ext_rst_i = 1; step(); ext_rst_i = 0;
    chk("R4", "core_rst", core_rst_o, 1); chk("R4", "clk_en", clk_en_o, 1);
    chk("R4", "no resume", resume_o, 0);
    chk("R4", "pd held", pd_o, 0); chk("R4", "to held", to_o, 1);
    step();
    chk("R4", "core_rst single", core_rst_o, 0);
  endtask

  task automatic t_wdt_run();
    wdt_tmo_i = 1; step();
    chk("R10", "disabled no reset", core_rst_o, 0);
    chk("R10", "disabled to", to_o, 1);
    wdt_en_i = 1; step(); wdt_tmo_i = 0;
    chk("R10", "core_rst", core_rst_o, 1);
    chk("R10", "to cleared", to_o, 0);
    chk("R10", "pd held", pd_o, 0);
    step();
    chk("R10", "core_rst single", core_rst_o, 0);
    wdt_en_i = 0;
  endtask

  task automatic t_ignore_in_startup();
    osc_rc_i = 0;
    sleep_i = 1; step(); sleep_i = 0;
    irq_flag_i = 3'b001; irq_en_i = 3'b001; step();
    irq_flag_i = '0; irq_en_i = '0;
    sleep_i = 1; wdt_en_i = 1; wdt_tmo_i = 1; step();
    sleep_i = 0; wdt_en_i = 0; wdt_tmo_i = 0;
    chk("R11", "no reset", core_rst_o, 0);
    chk("R11", "to held", to_o, 1);
    chk("R11", "pd held", pd_o, 0);
    for (int i = 2; i < OST; i++) begin
      step();
      chk("R11", "resume held off", resume_o, 0);
    end
    step();
    chk("R11", "resume on time", resume_o, 1);
    sleep_i = 1; step(); sleep_i = 0;
    chk("R11", "sleep ignored in resume", clk_en_o, 1);
    repeat (INSN) step();
    chk("R11", "running after resume", clk_en_o, 1);
  endtask

  initial begin
    t_reset();
    t_irq_xtal_gie0();
    t_irq_rc_gie1();
    t_wdt_wake();
    t_pending_at_sleep();
    t_ext_rst_in_sleep();
    t_wdt_run();
    t_ignore_in_startup();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule